// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets clocked logic read and write an external asynchronous static RAM organised as 1M words of 16 bits. The host side is a single-access request port: the host raises a request together with a write flag, a 20-bit word address, write data and a per-byte enable, and the controller answers with a one-clock completion pulse (and captured read data for reads). Between accesses the memory is put into standby by deasserting both chip selects.

On the memory side the controller drives a select pair of opposite polarity, a write strobe, an output enable, one active-low enable per byte lane, and a data bus split into output value, output-enable and input value so that the pad ring can build the tri-state buffer. Every access is stretched by a cycle counter to at least the memory's 55 ns minimum cycle, computed from a clock-period parameter. Writes put one clock of address setup before the strobe and one clock of recovery after it, keep the output enable off for the whole write, and drive the bus only from the strobe's start until one clock after it ends.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, host_ready is 1, host_done is 0, mem_sel_n is 1, mem_sel is 0, mem_we_n and mem_oe_n are 1, both mem_lane_n bits are 1 and mem_dq_oe is 0.
- R2: The memory is selected (mem_sel_n 0 and mem_sel 1 together) only while an access is in progress; whenever the controller is idle both selects are inactive and both lane enables are 1.
- R3: Every access lasts N = max(ceil(55000 ps / CLK_PERIOD_PS), 3) clocks from acceptance to the done pulse (N = 11 at 5 ns). A write holds mem_we_n low for exactly N-2 consecutive clocks, preceded by at least one selected clock with mem_we_n high and followed by one selected clock with mem_we_n high.
- R4: mem_addr and mem_lane_n do not change while mem_we_n is low.
- R5: mem_oe_n is 1 whenever mem_we_n is 0 or mem_dq_oe is 1; during a read mem_oe_n is 0 and mem_we_n is 1.
- R6: mem_dq_oe is 1 on every strobe clock and on the one clock after mem_we_n rises, and 0 otherwise; while driven, mem_dq_out equals the host write data.
- R7: host_be bit 0 enables the lower lane (data bits 7:0, mem_lane_n bit 0) and host_be bit 1 the upper lane (data bits 15:8, mem_lane_n bit 1), both active-low on the memory side; a write changes only the enabled bytes.
- R8: Read data is taken from mem_dq_in on the last clock of the read and appears on host_rdata with host_done; bytes of a disabled lane read as zero.
- R9: host_done is a one-clock pulse; host_ready is 0 for the whole access, and a request raised while host_ready is 0 and dropped before it returns starts no access.
- R10: A write with host_be = 00 leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Access request, taken when host_ready is 1 |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit 0 lower, bit 1 upper, active high |
| host_ready | output | 1 | Controller idle and able to accept |
| host_done | output | 1 | One-clock completion pulse |
| host_rdata | output | 16 | Captured read data, disabled bytes zero |
| mem_addr | output | 20 | Memory address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | 2 | Lane enables, bit 0 lower, bit 1 upper, active low |
| mem_dq_out | output | 16 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | 1 = drive the data bus, 0 = high impedance |
| mem_dq_in | input | 16 | Value read from the data bus |

## Verification
The bench aims at the write strobe's length and its surrounding setup and recovery clocks, where an off-by-one counter would shorten the pulse below the memory's minimum or move the address while the strobe is low. It writes single bytes and then reads with partial enables while the memory model places junk on disabled lanes, so a controller that swapped the lanes, wrote a disabled byte or failed to zero an unread byte returns a wrong word. It also raises a request mid-access and issues a write with no lanes, where a careless design would start a phantom second access or corrupt a word.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and elaboration-time helpers for the SRAM byte-lane controller.
package sram_ctrl_pkg;

    // Access sequencer states: one read state, three write phases.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WSTROBE,
        ST_WRECOV,
        ST_READ
    } seq_state_t;

    // Number of clocks needed to cover a span, rounded up.
    function automatic int unsigned cycles_covering(input int unsigned span_ps,
                                                    input int unsigned period_ps);
        return (span_ps + period_ps - 1) / period_ps;
    endfunction

    // Raise a count to a floor value.
    function automatic int unsigned at_least(input int unsigned value,
                                             input int unsigned floor_v);
        return (value < floor_v) ? floor_v : value;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
// Access sequencer: accepts a request when idle and walks it through the
// read state or the setup/strobe/recovery write phases, each timed by a
// cycle counter. Assumes STROBE_CYC >= 1 and ACC_CYC = STROBE_CYC + 2.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ACC_CYC    = 11,
    parameter int unsigned STROBE_CYC = 9,
    parameter int unsigned CNT_W      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       req_we,
    output seq_state_t state_q,
    output logic       accept,
    output logic       capture,
    output logic       done_q
);

    localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] READ_LAST   = CNT_W'(ACC_CYC - 1);

    seq_state_t       nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    // Next-state selection and end-of-access detection.
    always_comb begin
        nxt  = state_q;
        last = 1'b0;
        case (state_q)
            ST_IDLE:    if (req) nxt = req_we ? ST_WSETUP : ST_READ;
            ST_WSETUP:  nxt = ST_WSTROBE;
            ST_WSTROBE: if (cnt_q == STROBE_LAST) nxt = ST_WRECOV;
            ST_WRECOV: begin
                nxt  = ST_IDLE;
                last = 1'b1;
            end
            ST_READ: if (cnt_q == READ_LAST) begin
                nxt  = ST_IDLE;
                last = 1'b1;
            end
            default:    nxt = ST_IDLE;
        endcase
    end

    assign accept  = (state_q == ST_IDLE) && req;
    assign capture = (state_q == ST_READ) && (cnt_q == READ_LAST);

    // State, phase counter and completion pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= nxt;
            cnt_q   <= (nxt != state_q) ? '0 : cnt_q + 1'b1;
            done_q  <= last;
        end
    end

endmodule

// File: rtl/sram_ctrl_lane.sv
// One byte lane: holds the lane's enable and write byte from the accepted
// request and captures the read byte, forcing zero when the lane is off.
module sram_ctrl_lane (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       capture,
    input  logic       be_in,
    input  logic [7:0] wbyte_in,
    input  logic [7:0] rbyte_in,
    output logic       en_q,
    output logic [7:0] wbyte_q,
    output logic [7:0] rbyte_q
);

    // Request fields latched at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            wbyte_q <= '0;
        end else if (load) begin
            en_q    <= be_in;
            wbyte_q <= wbyte_in;
        end
    end

    // Read byte taken on the last read clock, zero for a disabled lane.
    always_ff @(posedge clk) begin
        if (!rst_n)       rbyte_q <= '0;
        else if (capture) rbyte_q <= en_q ? rbyte_in : 8'h00;
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
// Top of the asynchronous SRAM byte-lane controller. Turns single host
// requests into timed memory accesses; all memory outputs decode from
// registers. Assumes DATA_W is a multiple of 8 and that the pad ring builds
// the tri-state buffer from mem_dq_out / mem_dq_oe / mem_dq_in.
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned CLK_PERIOD_PS = 5000,
    parameter int unsigned MIN_CYCLE_PS  = 55000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [DATA_W-1:0]     host_wdata,
    input  logic [DATA_W/8-1:0]   host_be,
    output logic                  host_ready,
    output logic                  host_done,
    output logic [DATA_W-1:0]     host_rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_sel_n,
    output logic                  mem_sel,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic [DATA_W/8-1:0]   mem_lane_n,
    output logic [DATA_W-1:0]     mem_dq_out,
    output logic                  mem_dq_oe,
    input  logic [DATA_W-1:0]     mem_dq_in
);

    localparam int unsigned LANES      = DATA_W / 8;
    localparam int unsigned ACC_CYC    = at_least(cycles_covering(MIN_CYCLE_PS, CLK_PERIOD_PS), 3);
    localparam int unsigned STROBE_CYC = ACC_CYC - 2;
    localparam int unsigned CNT_W      = $clog2(ACC_CYC + 1);

    seq_state_t        state_q;
    logic              accept;
    logic              capture;
    logic              active;
    logic [LANES-1:0]  lane_en;
    logic [ADDR_W-1:0] addr_q;

    sram_ctrl_seq #(
        .ACC_CYC    (ACC_CYC),
        .STROBE_CYC (STROBE_CYC),
        .CNT_W      (CNT_W)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (host_req),
        .req_we  (host_we),
        .state_q (state_q),
        .accept  (accept),
        .capture (capture),
        .done_q  (host_done)
    );

    // Address register, loaded only at acceptance while the memory is deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= host_addr;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_ctrl_lane lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (accept),
            .capture  (capture),
            .be_in    (host_be[g]),
            .wbyte_in (host_wdata[8*g +: 8]),
            .rbyte_in (mem_dq_in[8*g +: 8]),
            .en_q     (lane_en[g]),
            .wbyte_q  (mem_dq_out[8*g +: 8]),
            .rbyte_q  (host_rdata[8*g +: 8])
        );
    end

    // Memory control decode from the sequencer state.
    always_comb begin
        active     = (state_q != ST_IDLE);
        host_ready = !active;
        mem_addr   = addr_q;
        mem_sel_n  = !active;
        mem_sel    = active;
        mem_we_n   = (state_q != ST_WSTROBE);
        mem_oe_n   = (state_q != ST_READ);
        mem_dq_oe  = (state_q == ST_WSTROBE) || (state_q == ST_WRECOV);
        mem_lane_n = ~(lane_en & {LANES{active}});
    end

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
// Protocol checker for the SRAM byte-lane controller, bound to the top.
// Watches only the host and memory ports; the strobe window is measured
// with a counter so no parameter-deep $past is needed.
module sram_lane_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned LANES         = 2,
    parameter int unsigned CLK_PERIOD_PS = 5000,
    parameter int unsigned MIN_CYCLE_PS  = 55000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ready,
    input logic              host_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [LANES-1:0]  mem_lane_n,
    input logic              mem_dq_oe
);

    localparam int unsigned ACC_CYC    = at_least(cycles_covering(MIN_CYCLE_PS, CLK_PERIOD_PS), 3);
    localparam int unsigned STROBE_CYC = ACC_CYC - 2;
    localparam int unsigned CNT_W      = $clog2(ACC_CYC + 1);

    logic [CNT_W-1:0] lo_cnt;

    // Length of the current run of low write-strobe clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)        lo_cnt <= '0;
        else if (mem_we_n) lo_cnt <= '0;
        else               lo_cnt <= lo_cnt + 1'b1;
    end

    assert_idle_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_sel_n && !mem_sel && (&mem_lane_n)));

    assert_sel_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_n != mem_sel);

    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (lo_cnt == CNT_W'(STROBE_CYC)));

    assert_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_sel_n && mem_we_n));

    assert_recovery_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_sel_n);

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> (mem_we_n || ($stable(mem_addr) && $stable(mem_lane_n))));

    assert_no_contend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || mem_dq_oe) |-> mem_oe_n);

    assert_drive_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    assert_drive_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && mem_we_n) |=> !mem_dq_oe);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sel_n |-> !host_ready);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .LANES         (DATA_W / 8),
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .MIN_CYCLE_PS  (MIN_CYCLE_PS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ready (host_ready),
    .host_done  (host_done),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_lane_n (mem_lane_n),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb_top;

    localparam int ACC_EXP    = (55000 + 5000 - 1) / 5000;  // 11 clocks at 5 ns
    localparam int STROBE_EXP = ACC_EXP - 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [19:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_be = '0;
    logic        host_ready, host_done;
    logic [15:0] host_rdata;
    logic [19:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'h5A5A;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] sram_q [int];
    logic [15:0] exp_q  [int];

    sram_lane_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #2.5 clk = ~clk;

    // Memory model: writes under select+strobe per lane, reads put junk on off lanes.
    always @(negedge clk) begin
        logic [15:0] w;
        int key;
        key = int'(mem_addr);
        w = sram_q.exists(key) ? sram_q[key] : 16'h0000;
        if (!mem_sel_n && mem_sel && !mem_we_n) begin
            if (!mem_lane_n[0]) w[7:0]  = mem_dq_oe ? mem_dq_out[7:0]  : 8'hEE;
            if (!mem_lane_n[1]) w[15:8] = mem_dq_oe ? mem_dq_out[15:8] : 8'hEE;
            sram_q[key] = w;
        end
        if (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n)
            mem_dq_in = {mem_lane_n[1] ? 8'hC3 : w[15:8], mem_lane_n[0] ? 8'h3C : w[7:0]};
        else
            mem_dq_in = 16'h5A5A;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [19:0] a, input logic [1:0] be);
        logic [15:0] w;
        w = exp_q.exists(int'(a)) ? exp_q[int'(a)] : 16'h0000;
        return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    endfunction

    function automatic logic [15:0] exp_merge(input logic [19:0] a, input logic [15:0] d,
                                              input logic [1:0] be);
        logic [15:0] w;
        w = exp_q.exists(int'(a)) ? exp_q[int'(a)] : 16'h0000;
        if (be[0]) w[7:0]  = d[7:0];
        if (be[1]) w[15:8] = d[15:8];
        return w;
    endfunction

    // One host access with protocol checks; returns read data.
    task automatic access(input logic we, input logic [19:0] a, input logic [15:0] wd,
                          input logic [1:0] be, output logic [15:0] rd);
        int lat, strobes;
        bit data_ok;
        logic [1:0] lanes_seen;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd; host_be = be;
        @(negedge clk);
        host_req = 1'b0;
        check(!host_ready, "R9 busy", 32'(host_ready), 0);
        lat = 0; strobes = 0; data_ok = 1; lanes_seen = 2'b11;
        while (!host_done && lat < 100) begin
            if (!mem_we_n) begin
                strobes++;
                lanes_seen = mem_lane_n;
                if (!mem_dq_oe || mem_dq_out != wd) data_ok = 0;
            end
            if (!mem_oe_n) lanes_seen = mem_lane_n;
            @(negedge clk);
            lat++;
        end
        rd = host_rdata;
        check(lat == ACC_EXP, "R3 access length", 32'(lat), 32'(ACC_EXP));
        check(strobes == (we ? STROBE_EXP : 0), "R3 strobe clocks", 32'(strobes),
              32'(we ? STROBE_EXP : 0));
        if (we) check(data_ok, "R6 write data driven", 32'(data_ok), 1);
        check(lanes_seen == ~be, "R7 lane enables", 32'(lanes_seen), 32'(~be));
        if (we) exp_q[int'(a)] = exp_merge(a, wd, be);
        else    check(rd == exp_read(a, be), "R8 read data", 32'(rd), 32'(exp_read(a, be)));
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(host_ready && !host_done, "R1 host side", {host_ready, host_done}, 2'b10);
        check(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && mem_lane_n == 2'b11 && !mem_dq_oe,
              "R1 memory side", {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe},
              7'b1011110);
        // R2 idle standby
        repeat (3) @(negedge clk);
        check(mem_sel_n && !mem_sel && mem_lane_n == 2'b11, "R2 standby",
              {mem_sel_n, mem_sel, mem_lane_n}, 4'b1011);
        // Full words at the address extremes
        access(1'b1, 20'h00000, 16'h1234, 2'b11, rd);
        access(1'b1, 20'hFFFFF, 16'hBEEF, 2'b11, rd);
        access(1'b0, 20'h00000, 16'h0, 2'b11, rd);
        access(1'b0, 20'hFFFFF, 16'h0, 2'b11, rd);
        // R7 single-lane writes then merged read
        access(1'b1, 20'h00042, 16'hAA11, 2'b01, rd);
        access(1'b1, 20'h00042, 16'h22BB, 2'b10, rd);
        access(1'b0, 20'h00042, 16'h0, 2'b11, rd);
        check(rd == 16'h2211, "R7 merged bytes", 32'(rd), 32'h2211);
        // R8 partial reads zero the disabled lane
        access(1'b0, 20'hFFFFF, 16'h0, 2'b01, rd);
        check(rd == 16'h00EF, "R8 upper zeroed", 32'(rd), 32'h00EF);
        access(1'b0, 20'hFFFFF, 16'h0, 2'b10, rd);
        check(rd == 16'hBE00, "R8 lower zeroed", 32'(rd), 32'hBE00);
        access(1'b0, 20'hFFFFF, 16'h0, 2'b00, rd);
        check(rd == 16'h0000, "R8 no lanes", 32'(rd), 0);
        // R10 write with no lanes
        access(1'b1, 20'h00000, 16'hFFFF, 2'b00, rd);
        access(1'b0, 20'h00000, 16'h0, 2'b11, rd);
        check(rd == 16'h1234, "R10 unchanged", 32'(rd), 32'h1234);
        // R9 request raised mid-access is ignored
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 20'h00777; host_wdata = 16'h0F0F;
        host_be = 2'b11;
        @(negedge clk);
        host_req = 1'b0;
        repeat (3) @(negedge clk);
        host_req = 1'b1; host_addr = 20'h00100; host_wdata = 16'hDEAD;
        @(negedge clk);
        host_req = 1'b0;
        while (!host_done) @(negedge clk);
        exp_q[int'(20'h00777)] = 16'h0F0F;
        repeat (3) @(negedge clk);
        check(host_ready && mem_sel_n, "R9 no phantom access", {host_ready, mem_sel_n}, 2'b11);
        access(1'b0, 20'h00100, 16'h0, 2'b11, rd);
        check(rd == 16'h0000, "R9 ignored request", 32'(rd), 0);
        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [2:0] idx;
            logic [19:0] a;
            idx = 3'($urandom % 6);
            a = (idx == 0) ? 20'h00000 : (idx == 1) ? 20'hFFFFF : {idx, 14'h0, idx};
            access(1'($urandom), a, 16'($urandom), 2'($urandom), rd);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule